// File: doc/BRIEF.md
# Two-Stream Dispatch and Retire Arbiter

This block decides, every cycle, which of two instruction streams owns the trace dispatch stage and which owns the trace retire stage of a redundantly executing core. The leading stream runs ahead and pushes each retired trace into a delay queue. The trailing redundant stream re-executes those traces from the queue and checks them. Each stage moves one whole trace per cycle, so a stage belongs to exactly one stream in any cycle.

Priority depends on how full the delay queue is. The queue counts as full while its free trace entries are at or below the configured number of execution elements. That reserve means every leading trace still in flight can always retire into the queue, so the two streams cannot deadlock. When the queue is full, the redundant stream is favoured at both stages. Otherwise the leading stream is favoured at both stages. If the favoured stream is not requesting, the other stream gets the stage, subject to two hard blocks that protect the queue.

The free-entry count and the element count are sampled into registers every cycle. Both grants are combinational from those registered values and the current requests.

Top module: `two_stream_arb`

## Requirements
- R1: `disp_gnt_o` is zero or one-hot. Bit 0 grants the leading stream and bit 1 grants the redundant stream.
- R2: `ret_gnt_o` is zero or one-hot, with the same bit assignment as R1.
- R3: On each clock edge the arbiter samples `free_cnt_i` and `pe_cnt_i`. The queue is full exactly when the sampled free count is less than or equal to the sampled element count. Reset leaves the sampled free count at `DEPTH` and the sampled element count at 0, which means empty and not full.
- R4: For dispatch, the redundant stream has priority while the queue is full. The leading stream has priority while it is not full.
- R5: For retire, the leading stream has priority while the queue is not full. The redundant stream has priority while it is full.
- R6: If the favoured stream is not requesting a stage, or is blocked from it, an eligible request from the other stream is granted.
- R7: The leading stream is never granted retire while the sampled free count is 0.
- R8: The redundant stream is never granted dispatch while the queue holds no entry, that is, while the sampled free count is at least `DEPTH`.
- R9: A grant bit is set only for a stream whose request is asserted in the same cycle.
- R10: A change in the requests changes the grants within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lead_disp_req_i | input | 1 | Leading stream has a trace ready to dispatch |
| red_disp_req_i | input | 1 | Redundant stream has a trace ready to dispatch |
| lead_ret_req_i | input | 1 | Leading stream has a trace ready to retire |
| red_ret_req_i | input | 1 | Redundant stream has a trace ready to retire |
| free_cnt_i | input | FREE_W | Free trace entries in the delay queue |
| pe_cnt_i | input | PE_W | Configured number of execution elements |
| disp_gnt_o | output | 2 | Dispatch grant: bit 0 leading, bit 1 redundant |
| ret_gnt_o | output | 2 | Retire grant: bit 0 leading, bit 1 redundant |

## Verification
The bench targets the full threshold at its edges: free equal to the element count, one above it, and one below it. A design that compares with strict less-than would keep favouring the leading stream while the reserve is already used up, and could deadlock. The bench also drives free counts of 0 and `DEPTH` with only the blocked stream requesting. A missing block would then show as a leading retire into a queue with no room, or as a redundant dispatch with nothing to check against. Finally, the bench changes the status inputs and the requests in the same cycle, which exposes a design that reacts to the unregistered count or that delays the grant by a cycle.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [0:0] {
    STREAM_LEAD = 1'b0,
    STREAM_RED  = 1'b1
  } stream_e;

  localparam int unsigned NUM_STREAMS = 2;

  typedef logic [NUM_STREAMS-1:0] stream_vec_t;
endpackage

// File: rtl/tsa_status.sv
module tsa_status #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned MAX_PE = 8,
  localparam int unsigned FREE_W = $clog2(DEPTH + 1),
  localparam int unsigned PE_W   = $clog2(MAX_PE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREE_W-1:0] free_cnt_i,
  input  logic [PE_W-1:0]   pe_cnt_i,
  output logic [FREE_W-1:0] free_q_o,
  output logic [PE_W-1:0]   pe_q_o,
  output logic              full_o,
  output logic              has_entry_o,
  output logic              has_room_o
);
  logic [FREE_W-1:0] free_q;
  logic [PE_W-1:0]   pe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= FREE_W'(DEPTH);
      pe_q   <= '0;
    end else begin
      free_q <= free_cnt_i;
      pe_q   <= pe_cnt_i;
    end
  end

  // Widen both operands before comparing so the widths can differ.
  localparam int unsigned CMP_W = (FREE_W > PE_W) ? FREE_W : PE_W;

  always_comb begin
    full_o      = CMP_W'(free_q) <= CMP_W'(pe_q);
    has_entry_o = free_q < FREE_W'(DEPTH);
    has_room_o  = free_q != '0;
  end

  assign free_q_o = free_q;
  assign pe_q_o   = pe_q;
endmodule

// File: rtl/tsa_stage_arb.sv
module tsa_stage_arb
  import tsa_pkg::*;
(
  input  stream_vec_t req_i,
  input  stream_vec_t elig_i,
  input  logic        prefer_red_i,
  output stream_vec_t gnt_o
);
  stream_vec_t cand;

  always_comb begin
    cand  = req_i & elig_i;
    gnt_o = '0;
    if (prefer_red_i) begin
      if (cand[STREAM_RED])       gnt_o[STREAM_RED]  = 1'b1;
      else if (cand[STREAM_LEAD]) gnt_o[STREAM_LEAD] = 1'b1;
    end else begin
      if (cand[STREAM_LEAD])      gnt_o[STREAM_LEAD] = 1'b1;
      else if (cand[STREAM_RED])  gnt_o[STREAM_RED]  = 1'b1;
    end
  end
endmodule

// File: rtl/two_stream_arb.sv
module two_stream_arb
  import tsa_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned MAX_PE = 8,
  localparam int unsigned FREE_W = $clog2(DEPTH + 1),
  localparam int unsigned PE_W   = $clog2(MAX_PE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lead_disp_req_i,
  input  logic              red_disp_req_i,
  input  logic              lead_ret_req_i,
  input  logic              red_ret_req_i,
  input  logic [FREE_W-1:0] free_cnt_i,
  input  logic [PE_W-1:0]   pe_cnt_i,
  output logic [1:0]        disp_gnt_o,
  output logic [1:0]        ret_gnt_o
);
  logic [FREE_W-1:0] free_q;
  logic [PE_W-1:0]   pe_q;
  logic              q_full, q_has_entry, q_has_room;

  tsa_status #(.DEPTH(DEPTH), .MAX_PE(MAX_PE)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .free_cnt_i  (free_cnt_i),
    .pe_cnt_i    (pe_cnt_i),
    .free_q_o    (free_q),
    .pe_q_o      (pe_q),
    .full_o      (q_full),
    .has_entry_o (q_has_entry),
    .has_room_o  (q_has_room)
  );

  stream_vec_t disp_req, disp_elig, ret_req, ret_elig;
  stream_vec_t disp_gnt, ret_gnt;

  always_comb begin
    disp_req  = {red_disp_req_i, lead_disp_req_i};
    ret_req   = {red_ret_req_i, lead_ret_req_i};
    // redundant dispatch needs a checked entry; leading retire needs room
    disp_elig = {q_has_entry, 1'b1};
    ret_elig  = {1'b1, q_has_room};
  end

  tsa_stage_arb u_disp_arb (
    .req_i        (disp_req),
    .elig_i       (disp_elig),
    .prefer_red_i (q_full),
    .gnt_o        (disp_gnt)
  );

  tsa_stage_arb u_ret_arb (
    .req_i        (ret_req),
    .elig_i       (ret_elig),
    .prefer_red_i (q_full),
    .gnt_o        (ret_gnt)
  );

  assign disp_gnt_o = disp_gnt;
  assign ret_gnt_o  = ret_gnt;
endmodule

// File: rtl/two_stream_arb_chk.sv
module two_stream_arb_chk #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned MAX_PE = 8,
  localparam int unsigned FREE_W = $clog2(DEPTH + 1),
  localparam int unsigned PE_W   = $clog2(MAX_PE + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lead_disp_req_i,
  input logic              red_disp_req_i,
  input logic              lead_ret_req_i,
  input logic              red_ret_req_i,
  input logic [FREE_W-1:0] free_q,
  input logic [PE_W-1:0]   pe_q,
  input logic [1:0]        disp_gnt_o,
  input logic [1:0]        ret_gnt_o
);
  logic full_c;
  assign full_c = 32'(free_q) <= 32'(pe_q);

  assert_disp_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_gnt_o));

  assert_ret_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ret_gnt_o));

  assert_full_red_disp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_c && red_disp_req_i && 32'(free_q) < DEPTH) |-> disp_gnt_o == 2'b10);

  assert_open_lead_ret_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_c && lead_ret_req_i && free_q != '0) |-> ret_gnt_o == 2'b01);

  assert_fallback_ret_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (red_ret_req_i && !lead_ret_req_i) |-> ret_gnt_o == 2'b10);

  assert_no_ret_when_no_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_q == '0) |-> !ret_gnt_o[0]);

  assert_no_disp_when_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(free_q) >= DEPTH) |-> !disp_gnt_o[1]);

  assert_grant_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((disp_gnt_o & ~{red_disp_req_i, lead_disp_req_i}) == 2'b00) &&
    ((ret_gnt_o & ~{red_ret_req_i, lead_ret_req_i}) == 2'b00));
endmodule

bind two_stream_arb two_stream_arb_chk #(.DEPTH(DEPTH), .MAX_PE(MAX_PE)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lead_disp_req_i (lead_disp_req_i),
  .red_disp_req_i  (red_disp_req_i),
  .lead_ret_req_i  (lead_ret_req_i),
  .red_ret_req_i   (red_ret_req_i),
  .free_q          (free_q),
  .pe_q            (pe_q),
  .disp_gnt_o      (disp_gnt_o),
  .ret_gnt_o       (ret_gnt_o)
);

// File: tb/tb_two_stream_arb.sv
module tb_two_stream_arb;
  localparam int unsigned DEPTH  = 32;
  localparam int unsigned MAX_PE = 8;
  localparam int unsigned FREE_W = $clog2(DEPTH + 1);
  localparam int unsigned PE_W   = $clog2(MAX_PE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld, rd, lr, rr;
  logic [FREE_W-1:0] free_cnt;
  logic [PE_W-1:0]   pe_cnt;
  logic [1:0] disp_gnt, ret_gnt;

  int checks = 0;
  int errors = 0;
  int prev_free = DEPTH;
  int prev_pe = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  two_stream_arb #(.DEPTH(DEPTH), .MAX_PE(MAX_PE)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lead_disp_req_i(ld), .red_disp_req_i(rd),
    .lead_ret_req_i(lr), .red_ret_req_i(rr),
    .free_cnt_i(free_cnt), .pe_cnt_i(pe_cnt),
    .disp_gnt_o(disp_gnt), .ret_gnt_o(ret_gnt)
  );

  function automatic logic [1:0] pick(bit lead_ok, bit red_ok, bit red_first);
    if (red_first) return red_ok ? 2'b10 : (lead_ok ? 2'b01 : 2'b00);
    return lead_ok ? 2'b01 : (red_ok ? 2'b10 : 2'b00);
  endfunction

  task automatic cmp(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (free_prev=%0d pe_prev=%0d)",
               tag, act, exp, prev_free, prev_pe);
    end
  endtask

  // drive at negedge, check before the next posedge, then record sampled status
  task automatic step(bit l_d, bit r_d, bit l_r, bit r_r, int fr, int pe,
                      string dtag, string rtag);
    bit full;
    logic [1:0] ed, er;
    @(negedge clk);
    ld = l_d; rd = r_d; lr = l_r; rr = r_r;
    free_cnt = FREE_W'(fr); pe_cnt = PE_W'(pe);
    #5;
    full = prev_free <= prev_pe;
    ed = pick(l_d, r_d && (prev_free < DEPTH), full);
    er = pick(l_r && (prev_free > 0), r_r, full);
    cmp(dtag, disp_gnt, ed);
    cmp(rtag, ret_gnt, er);
    if (rst_n) begin
      prev_free = fr;
      prev_pe = pe;
    end
  endtask

  initial begin
    ld = 0; rd = 0; lr = 0; rr = 0; free_cnt = '0; pe_cnt = '0;
    #35 rst_n = 1'b1;
    // R9 reset state: queue treated as empty, nothing granted without requests
    step(0, 0, 0, 0, 10, 4, "R9 reset idle disp", "R9 reset idle ret");
    // R3 / R4 / R5 threshold: free == pe is full
    step(1, 1, 1, 1, 4, 4, "R1 setup", "R2 setup");
    step(1, 1, 1, 1, 5, 4, "R3 R4 free==pe disp red", "R3 R5 free==pe ret red");
    step(1, 1, 1, 1, 3, 4, "R3 R4 free>pe disp lead", "R3 R5 free>pe ret lead");
    step(1, 1, 1, 1, 3, 4, "R3 R4 free<pe disp red", "R3 R5 free<pe ret red");
    // R6 fallback both ways
    step(1, 0, 0, 1, 20, 2, "R6 full lone lead disp", "R6 full lone red ret");
    step(0, 1, 1, 0, 20, 2, "R6 open lone red disp", "R6 open lone lead ret");
    // R7 zero free: lead retire blocked even as lone requester
    step(0, 0, 0, 0, 0, 2, "R7 setup disp", "R7 setup ret");
    step(0, 1, 1, 0, 0, 2, "R7 R8 full red disp", "R7 no room lead ret");
    step(0, 0, 1, 1, DEPTH, 0, "R7 idle", "R7 no room red fallback");
    // R8 empty queue: red dispatch blocked even as lone requester
    step(0, 1, 0, 0, DEPTH, 0, "R8 empty red disp", "R8 ret idle");
    step(1, 1, 0, 0, DEPTH, 0, "R8 empty lead fallback", "R8 ret idle2");
    // R10 requests change within a cycle with the same status
    step(0, 1, 0, 1, 10, 3, "R10 req swap a", "R10 req swap a ret");
    step(1, 0, 1, 0, 10, 3, "R10 req swap b", "R10 req swap b ret");
    // broad mix
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, DEPTH), $urandom_range(0, MAX_PE),
           "R4 R1 disp", "R5 R2 ret");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule